// File: doc/BRIEF.md
# Interleaved Multi-Bank Strided Vector Load Engine

This block reads a vector of words out of a memory split into eight independent banks. Consecutive word addresses sit in consecutive banks: the bank is chosen by the low address bits. Each bank needs several cycles per access. To hide that latency, the engine sends requests to different banks on successive cycles. A client starts a load with a base word address, a stride in words and an element count. The engine then issues at most one element request per cycle, walking base, base+stride, base+2·stride and so on. The returned elements stream out in request order, at up to one per cycle.

A bank that has accepted a request stays busy for its full latency. If the next element maps to a bank that is still busy, the engine waits and counts every such waiting cycle. A stride that shares no factor with the bank count visits all banks before it returns to any one of them, so the stream runs without a pause. Other strides come back to a bank too early and pay stall cycles. The banks hold a fixed read-only image that is computed from the word address; writing is not part of this block.

Top module: `vmem_strided_load`

## Requirements
- R1: The word at address a is held in bank a mod 8 (the three low address bits), and its value is {~a, a ^ 16'h96E1}: the upper 16 bits are the inverted address and the lower 16 bits are the address XOR 16'h96E1.
- R2: Element i of a load carries the word at address (base + i·stride) mod 2^16, so the address sequence wraps past 16'hFFFF.
- R3: When the accepting clock edge of `start` is counted as edge 0 and no stall occurs, element i is issued at edge i+1. Element i appears on the output after edge i+1+6. A 64-element load with stride 1 therefore presents its last element after edge 70 (64 + latency) with zero stalls.
- R4: Elements appear on `out_valid`/`out_data` strictly in request order, at most one per cycle. `out_index` runs from 0 to count−1.
- R5: A bank that accepts a request cannot accept another until 6 edges later. A request whose target bank is busy waits, and later elements wait behind it. Even strides therefore produce stalls: stride 8 with 10 elements costs 45 stall cycles.
- R6: `stall_count` rises by one in every cycle in which the pending request cannot issue because its bank is busy. An accepted `start` clears it to zero, and it holds its value while the engine is idle.
- R7: `busy` is high from the cycle after an accepted `start` until the cycle in which the last element is presented. In that cycle `busy` is low, `done` is high for exactly one cycle, and `out_valid` is high.
- R8: A `start` raised while `busy` is high is ignored. The running load's data, timing and stall count are unchanged.
- R9: An accepted `start` with an element count of 0 produces no output, leaves `busy` low and clears `stall_count`.
- R10: After reset, `busy`, `out_valid`, `done` and `stall_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new load; accepted only while `busy` is low |
| base_addr | input | 16 | Word address of element 0 |
| stride | input | 16 | Word distance between successive elements (mod 2^16) |
| elem_count | input | 8 | Number of elements to load (0 to 255) |
| busy | output | 1 | A load is in progress |
| out_valid | output | 1 | `out_data` holds a returned element this cycle |
| out_data | output | 32 | Returned element |
| out_index | output | 8 | Position of the returned element in the vector |
| done | output | 1 | One-cycle pulse together with the final element |
| stall_count | output | 16 | Bank-busy waiting cycles of the current or last load |

## Verification
The checker enforces a set of rules on every cycle:
- no request ever reaches a bank that is still busy;
- at most one bank returns data in a cycle;
- the output index follows request order;
- the stall counter steps exactly on waiting cycles, clears on an accepted start and holds while idle;
- `done` coincides with the final element.

Other properties can only be shown by the bench's scenarios, which compare against a cycle model of bank occupancy:
- the exact issue timing and total latency for coprime and conflicting strides;
- the data image, including address wrap;
- the precise stall totals;
- that a start while busy is ignored;
- the behaviour of a zero-length load.

// File: rtl/vmem_pkg.sv
// Shared constants and types of the strided vector load engine.
// Assumes: memory image width is twice the address width, address width <= 32.
package vmem_pkg;

    // Key folded into the low half of every word of the read-only image.
    localparam logic [31:0] IMAGE_KEY = 32'h5A3C_96E1;

    // Engine phase seen at the top level.
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

endpackage

// File: rtl/vmem_bank.sv
// One memory bank with a fixed access latency.
// Accepts a request only while free. Stays busy for LATENCY cycles and
// presents the word one cycle before it becomes free again, so that the
// collector registers it exactly LATENCY edges after acceptance.
// Assumes: LATENCY >= 2; the caller never drives acc_valid while free is low.
module vmem_bank #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned LATENCY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [IDX_W-1:0]  acc_idx,
    output logic              free,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [IDX_W-1:0]  rsp_idx
);
    import vmem_pkg::*;

    localparam int unsigned WAIT_W = $clog2(LATENCY + 1);
    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(LATENCY - 1);
    localparam logic [WAIT_W-1:0] WAIT_ONE  = WAIT_W'(1);

    logic [WAIT_W-1:0] wait_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] image_word;

    // Computed read-only image: inverted address above, keyed address below.
    assign image_word = {~addr_q, addr_q ^ IMAGE_KEY[ADDR_W-1:0]};
    assign free       = (wait_q == '0);

    // Occupancy countdown and capture of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (acc_valid) begin
            wait_q <= WAIT_LOAD;
            addr_q <= acc_addr;
            idx_q  <= acc_idx;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    // Response register, loaded on the last busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= (wait_q == WAIT_ONE);
            rsp_data  <= image_word;
            rsp_idx   <= idx_q;
        end
    end

endmodule

// File: rtl/vmem_issue.sv
// Strided address walker and request issuer.
// Holds the next element's address. Each cycle it sends that element to its
// bank if the bank is free, and otherwise waits and counts a stall.
// Assumes: NUM_BANKS is a power of two >= 2; launch only while inactive.
module vmem_issue #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned STALL_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 clear,
    input  logic [ADDR_W-1:0]    base,
    input  logic [ADDR_W-1:0]    step,
    input  logic [IDX_W-1:0]     count,
    input  logic [NUM_BANKS-1:0] bank_free,
    output logic                 req_valid,
    output logic [$clog2(NUM_BANKS)-1:0] req_bank,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [IDX_W-1:0]     req_idx,
    output logic                 active,
    output logic [STALL_W-1:0]   stall_count
);
    localparam int unsigned BANK_W = $clog2(NUM_BANKS);

    logic              active_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] step_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [BANK_W-1:0] target;
    logic              blocked;

    // Bank select from the low address bits; request goes out when free.
    always_comb begin
        target    = addr_q[BANK_W-1:0];
        blocked   = active_q && !bank_free[target];
        req_valid = active_q && bank_free[target];
        req_bank  = target;
        req_addr  = addr_q;
        req_idx   = idx_q;
        active    = active_q;
    end

    // Walk the address sequence and retire after the last element issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            step_q   <= '0;
            idx_q    <= '0;
            last_q   <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            addr_q   <= base;
            step_q   <= step;
            idx_q    <= '0;
            last_q   <= count - 1'b1;
        end else if (req_valid) begin
            addr_q <= addr_q + step_q;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == last_q) begin
                active_q <= 1'b0;
            end
        end
    end

    // Count cycles lost to a busy target bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_count <= '0;
        end else if (clear) begin
            stall_count <= '0;
        end else if (blocked) begin
            stall_count <= stall_count + 1'b1;
        end
    end

endmodule

// File: rtl/vmem_collect.sv
// Merges the bank responses into one in-order output stream.
// Fixed latency and one issue per cycle mean responses already arrive in
// request order, at most one per cycle, so a plain OR-merge suffices.
// Assumes: at most one rsp_valid bit is set in any cycle.
module vmem_collect #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_BANKS-1:0]              rsp_valid,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  rsp_data,
    input  logic [NUM_BANKS-1:0][IDX_W-1:0]   rsp_idx,
    input  logic [IDX_W-1:0]                  last_idx,
    output logic                              final_seen,
    output logic                              out_valid,
    output logic [DATA_W-1:0]                 out_data,
    output logic [IDX_W-1:0]                  out_index,
    output logic                              out_last
);
    logic              any_rsp;
    logic [DATA_W-1:0] sel_data;
    logic [IDX_W-1:0]  sel_idx;

    // OR-merge of the single active bank response.
    always_comb begin
        sel_data = '0;
        sel_idx  = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (rsp_valid[b]) begin
                sel_data = sel_data | rsp_data[b];
                sel_idx  = sel_idx | rsp_idx[b];
            end
        end
        any_rsp    = |rsp_valid;
        final_seen = any_rsp && (sel_idx == last_idx);
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_index <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= any_rsp;
            out_data  <= sel_data;
            out_index <= sel_idx;
            out_last  <= final_seen;
        end
    end

endmodule

// File: rtl/vmem_strided_load.sv
// Top of the interleaved multi-bank strided vector load engine.
// Accepts a load while idle, issues elements round the banks and returns
// them in order. Busy ends with the cycle in which the final element shows.
// Assumes: NUM_BANKS a power of two >= 2, LATENCY >= 2, ADDR_W <= 32.
module vmem_strided_load #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned LATENCY   = 6,
    parameter int unsigned STALL_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [ADDR_W-1:0]     stride,
    input  logic [IDX_W-1:0]      elem_count,
    output logic                  busy,
    output logic                  out_valid,
    output logic [2*ADDR_W-1:0]   out_data,
    output logic [IDX_W-1:0]      out_index,
    output logic                  done,
    output logic [STALL_W-1:0]    stall_count
);
    import vmem_pkg::*;

    localparam int unsigned DATA_W = 2 * ADDR_W;
    localparam int unsigned BANK_W = $clog2(NUM_BANKS);

    eng_state_e                      state_q;
    logic                            accept;
    logic                            launch;
    logic [IDX_W-1:0]                last_idx_q;
    logic                            req_valid;
    logic [BANK_W-1:0]               req_bank;
    logic [ADDR_W-1:0]               req_addr;
    logic [IDX_W-1:0]                req_idx;
    logic                            eng_active;
    logic [NUM_BANKS-1:0]            bank_free;
    logic [NUM_BANKS-1:0]            rsp_valid;
    logic [NUM_BANKS-1:0][DATA_W-1:0] rsp_data;
    logic [NUM_BANKS-1:0][IDX_W-1:0]  rsp_idx;
    logic                            final_seen;
    logic                            out_last;

    assign accept = start && (state_q == ENG_IDLE);
    assign launch = accept && (elem_count != '0);
    assign busy   = (state_q == ENG_RUN);
    assign done   = out_last;

    // Phase control: run from launch until the final element is merged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ENG_IDLE;
            last_idx_q <= '0;
        end else if (launch) begin
            state_q    <= ENG_RUN;
            last_idx_q <= elem_count - 1'b1;
        end else if (state_q == ENG_RUN && final_seen) begin
            state_q <= ENG_IDLE;
        end
    end

    vmem_issue #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .NUM_BANKS(NUM_BANKS),
        .STALL_W  (STALL_W)
    ) issue_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .clear      (accept),
        .base       (base_addr),
        .step       (stride),
        .count      (elem_count),
        .bank_free  (bank_free),
        .req_valid  (req_valid),
        .req_bank   (req_bank),
        .req_addr   (req_addr),
        .req_idx    (req_idx),
        .active     (eng_active),
        .stall_count(stall_count)
    );

    // One bank per low-address value.
    for (genvar g = 0; g < int'(NUM_BANKS); g++) begin : g_bank
        logic hit;
        assign hit = req_valid && (req_bank == BANK_W'(g));

        vmem_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W),
            .LATENCY(LATENCY)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_valid(hit),
            .acc_addr (req_addr),
            .acc_idx  (req_idx),
            .free     (bank_free[g]),
            .rsp_valid(rsp_valid[g]),
            .rsp_data (rsp_data[g]),
            .rsp_idx  (rsp_idx[g])
        );
    end

    vmem_collect #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .NUM_BANKS(NUM_BANKS)
    ) collect_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_idx   (rsp_idx),
        .last_idx  (last_idx_q),
        .final_seen(final_seen),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_index (out_index),
        .out_last  (out_last)
    );

endmodule

// File: rtl/vmem_strided_load_chk.sv
// Protocol checker for the strided load engine, bound to the top module.
// Watches issue, bank occupancy, the output order and the stall counter.
module vmem_strided_load_chk #(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned STALL_W   = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic                         busy,
    input logic                         out_valid,
    input logic [IDX_W-1:0]             out_index,
    input logic                         done,
    input logic [STALL_W-1:0]           stall_count,
    input logic                         req_valid,
    input logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input logic [NUM_BANKS-1:0]         bank_free,
    input logic [NUM_BANKS-1:0]         rsp_valid,
    input logic                         eng_active
);
    logic [IDX_W-1:0] exp_idx_q;

    // Expected index of the next output element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_idx_q <= '0;
        end else if (start && !busy) begin
            exp_idx_q <= '0;
        end else if (out_valid) begin
            exp_idx_q <= exp_idx_q + 1'b1;
        end
    end

    // R5: never send a request to a bank that is still busy.
    p_issue_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> bank_free[req_bank]);

    // R4: at most one bank returns data per cycle.
    p_one_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R4: output elements come in request order.
    p_in_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_index == exp_idx_q));

    // R6: a waiting cycle adds exactly one stall.
    p_stall_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && !req_valid) |=> (stall_count == $past(stall_count) + 1'b1));

    // R6: accepted start clears the stall counter.
    p_stall_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (stall_count == '0));

    // R6: counter holds while no request is pending.
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_active && !(start && !busy)) |=> $stable(stall_count));

    // R7: done marks the final element and busy is already low.
    p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && !busy));

    // R9: nothing is issued while the engine is idle.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_active);

endmodule

bind vmem_strided_load vmem_strided_load_chk #(
    .IDX_W    (IDX_W),
    .NUM_BANKS(NUM_BANKS),
    .STALL_W  (STALL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_index  (out_index),
    .done       (done),
    .stall_count(stall_count),
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .bank_free  (bank_free),
    .rsp_valid  (rsp_valid),
    .eng_active (eng_active)
);

// File: tb/vmem_strided_load_tb.sv
`timescale 1ns/1ps
// Bench for the strided load engine: directed corner cases plus seeded
// random loads, checked against a cycle model of bank occupancy.
module vmem_strided_load_tb_top;

    localparam int LAT   = 6;
    localparam int BANKS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [15:0] stride = '0;
    logic [7:0]  elem_count = '0;
    logic        busy;
    logic        out_valid;
    logic [31:0] out_data;
    logic [7:0]  out_index;
    logic        done;
    logic [15:0] stall_count;

    int tests_run = 0;
    int tests_failed = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vmem_strided_load dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_addr  (base_addr),
        .stride     (stride),
        .elem_count (elem_count),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_index  (out_index),
        .done       (done),
        .stall_count(stall_count)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            tests_failed = tests_failed + 1;
            $display("FAIL R7 watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests_run = tests_run + 1;
        if (!ok) begin
            tests_failed = tests_failed + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1: image word of an address.
    function automatic logic [31:0] image_of(input logic [15:0] a);
        return {~a, a ^ 16'h96E1};
    endfunction

    // R3/R5: bank occupancy model; issue edges counted from the start edge.
    task automatic model(input logic [15:0] b, input logic [15:0] s, input int n,
                         output int stalls, output int last_edge);
        int free_at[BANKS];
        int prev = 0;
        stalls = 0;
        for (int k = 0; k < BANKS; k++) free_at[k] = 0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            int bk, want, t;
            a    = 16'(b + 16'(i) * s);
            bk   = int'(a[2:0]);
            want = (i == 0) ? 1 : prev + 1;
            t    = (free_at[bk] > want) ? free_at[bk] : want;
            stalls = stalls + (t - want);
            free_at[bk] = t + LAT;
            prev = t;
        end
        last_edge = prev + LAT;
    endtask

    // Run one load; optionally poke start while busy (R8).
    task automatic run_load(input logic [15:0] b, input logic [15:0] s,
                            input int n, input bit poke, input string tag);
        int exp_stalls, exp_last, cyc, got;
        bit finished, busy_bad, data_bad, idx_bad;
        longint bad_act, bad_exp;
        model(b, s, n, exp_stalls, exp_last);
        @(negedge clk);
        start = 1'b1; base_addr = b; stride = s; elem_count = 8'(n);
        @(negedge clk);
        start = 1'b0; base_addr = 16'hDEAD; stride = 16'h0001; elem_count = 8'd3;
        cyc = 0; got = 0; finished = 0; busy_bad = 0; data_bad = 0; idx_bad = 0;
        bad_act = 0; bad_exp = 0;
        while (!finished && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b1; base_addr = 16'h1234; stride = 16'd8; elem_count = 8'd1;
            end else if (poke && cyc == 4) begin
                start = 1'b0;
            end
            if (out_valid) begin
                if (out_index != 8'(got)) begin
                    idx_bad = 1; bad_act = out_index; bad_exp = got;
                end
                if (out_data != image_of(16'(b + 16'(got) * s))) begin
                    data_bad = 1; bad_act = out_data; bad_exp = image_of(16'(b + 16'(got) * s));
                end
                got++;
            end
            if (done) begin
                finished = 1;
                check(!busy, "R7", {tag, " busy low with last"}, busy, 0);
                check(out_valid, "R7", {tag, " done with data"}, out_valid, 1);
            end else if (!busy) begin
                busy_bad = 1;
            end
        end
        check(finished && cyc == exp_last, "R3", {tag, " last element edge"}, cyc, exp_last);
        check(got == n, "R4", {tag, " element count"}, got, n);
        check(!idx_bad, "R4", {tag, " order"}, bad_act, bad_exp);
        check(!data_bad, "R2", {tag, " data"}, bad_act, bad_exp);
        check(stall_count == 16'(exp_stalls), "R6", {tag, " stalls"}, stall_count, exp_stalls);
        check(!busy_bad, "R7", {tag, " busy during load"}, 0, 1);
        if (poke) check(stall_count == 16'(exp_stalls) && cyc == exp_last,
                        "R8", {tag, " start while busy ignored"}, cyc, exp_last);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd7781);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(!busy && !out_valid && !done && stall_count == 0, "R10", "reset state",
              {busy, out_valid, done}, 0);

        // R3: stride 1, 64 elements, zero stalls, last after 70 edges
        run_load(16'h0000, 16'd1, 64, 0, "stride1x64");
        check(stall_count == 0, "R3", "stride1 stall free", stall_count, 0);
        // R1: bank rule and image via a stride of 8 (one bank) and an odd stride
        run_load(16'h0005, 16'd8, 10, 0, "stride8x10");
        check(stall_count == 16'd45, "R5", "stride8 stall total", stall_count, 45);
        run_load(16'h0010, 16'd2, 16, 0, "stride2x16");
        run_load(16'h0003, 16'd4, 12, 0, "stride4x12");
        run_load(16'hFFF0, 16'd3, 24, 0, "stride3 wrap R1");
        run_load(16'h0100, 16'd1, 20, 1, "poke R8");

        // R9: zero-length load clears stall count and stays idle
        begin
            bit bad = 0;
            @(negedge clk);
            start = 1'b1; elem_count = 8'd0;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 6; i++) begin
                if (busy || out_valid || done) bad = 1;
                @(negedge clk);
            end
            check(!bad, "R9", "count 0 quiet", bad, 0);
            check(stall_count == 0, "R9", "count 0 clears stalls", stall_count, 0);
        end

        // Random mix, R2/R3/R5/R6
        for (int r = 0; r < 30; r++) begin
            logic [15:0] rb, rs;
            int rn;
            rb = 16'($urandom);
            rs = (r % 5 == 4) ? 16'($urandom) : 16'($urandom_range(0, 17));
            rn = int'($urandom_range(1, 48));
            run_load(rb, rs, rn, (r % 7 == 3), "random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule